// File: doc/BRIEF.md
# SPI Master Slave-Select and Status Front End

This block is the register-facing control layer of a small SPI master. Software reaches it through an 8-bit register bus with single-cycle read and write strobes. It holds a slave-select pattern, a status register with two sticky event flags and an automatic-select enable, and a byte data register. Writing the data register while the shifter is idle starts a one-byte transfer. The transfer uses mode 0 timing, sends the most significant bit first, and derives the serial clock from the system clock by a fixed divider. The byte captured from the slave can be read from the data register once the transfer-complete flag is set.

The four active-low select outputs work in one of two ways. In automatic mode they take the pattern only while a transfer is running, and they drive high whenever the shifter is idle. In static mode they always take the pattern. The transfer-complete flag and the write-collision flag are cleared by a two-step sequence: software reads the status register while a flag is set, and then reads or writes the data register. The register bus has no back-pressure. Every strobe is taken in the cycle it is presented, and read data is valid combinationally in that same cycle.

Top module: `spi_cs_ctrl`

## Requirements
- R1: After reset the select outputs are all high, the serial clock is low, status (address 0xED) reads 0x00 and the select register (address 0xEF) reads 0xFF.
- R2: A write to 0xEF stores bits 3:0 as the select pattern. Reading 0xEF returns the pattern in bits 3:0 and ones in bits 7:4.
- R3: When status bit 0 is 1, the select outputs equal the pattern from one system clock after the starting data write until one system clock after the last serial clock falling edge. At all other times they are all high.
- R4: When status bit 0 is 0, the select outputs equal the pattern at all times, whether or not a transfer runs.
- R5: A write to the data register (address 0xEE) while idle starts a transfer. The serial clock idles low. There is one setup clock, then each of the 8 bits is high for HALF_DIV clocks, with HALF_DIV low clocks between bits. MOSI changes only on falling edges and sends bit 7 first.
- R6: The byte shifted in on MISO, sampled while the serial clock is high with the first bit as bit 7, reads back at 0xEE from the cycle in which the complete flag sets.
- R7: Status bit 7 (transfer complete) sets one system clock after the last serial clock falling edge.
- R8: A data write while a transfer runs sets status bit 6 (write collision). The written byte is discarded and the byte being sent is not changed.
- R9: A status read taken while bit 7 or bit 6 is set arms a clear. The next data register read or write then clears both flags.
- R10: A data access without a prior arming status read leaves the flags unchanged. A write to any other register between the arming read and the data access cancels the clear.
- R11: A flag event in the same cycle as the clearing data access wins, so that flag stays set.
- R12: Status bits 5:1 read as 0. Bit 0 is writable. Bits 7 and 6 ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of bus_rd |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to slaves |
| miso | input | 1 | Serial data from slaves |
| sel_n | output | 4 | Active-low slave selects |

## Verification
The bench compares the serial clock and every select line against an arithmetic schedule at every system clock of each transfer. A design with the select window one clock off, or with a wrong divider, fails on the first mismatching cycle. It issues a colliding write in the middle of a transfer and checks the byte on MOSI, which catches a design that reloads the shifter on a collision. The clear sequence is tested with and without arming, with an intervening register write that must cancel it, and with the clearing data read landing in the exact cycle a transfer completes. A design that lets the clear win over the new event would lose the complete flag there.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_LEAD,
    ENG_HI,
    ENG_LO,
    ENG_TRAIL
  } eng_state_t;
endpackage

// File: rtl/spi_cs_shift.sv
module spi_cs_shift
  import spi_cs_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CNT_W = $clog2(HALF_DIV + 1);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  eng_state_t        state;
  logic [CNT_W-1:0]  div_cnt;
  logic [BIT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;

  assign busy = (state != ENG_IDLE);
  assign done = (state == ENG_TRAIL);
  assign sclk = (state == ENG_HI);
  assign mosi = tx_sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ENG_IDLE;
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_byte <= '0;
    end else begin
      case (state)
        ENG_IDLE: begin
          if (start) begin
            tx_sh <= tx_byte;
            state <= ENG_LEAD;
          end
        end
        ENG_LEAD: begin
          div_cnt <= '0;
          bit_cnt <= '0;
          state   <= ENG_HI;
        end
        ENG_HI: begin
          if (div_cnt == DIV_LAST) begin
            div_cnt <= '0;
            rx_sh   <= {rx_sh[DATA_W-2:0], miso};
            if (bit_cnt == BIT_LAST) begin
              state <= ENG_TRAIL;
            end else begin
              tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
              bit_cnt <= bit_cnt + 1'b1;
              state   <= ENG_LO;
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        ENG_LO: begin
          if (div_cnt == DIV_LAST) begin
            div_cnt <= '0;
            state   <= ENG_HI;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        ENG_TRAIL: begin
          rx_byte <= rx_sh;
          state   <= ENG_IDLE;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cs_flags.sv
module spi_cs_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic done_evt,
  input  logic coll_evt,
  input  logic stat_rd,
  input  logic data_acc,
  input  logic other_wr,
  output logic tc_flag,
  output logic wcol_flag
);
  logic armed;
  logic clr;

  assign clr = armed && data_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      tc_flag   <= 1'b0;
      wcol_flag <= 1'b0;
    end else begin
      if (other_wr || data_acc)
        armed <= 1'b0;
      else if (stat_rd && (tc_flag || wcol_flag))
        armed <= 1'b1;

      if (done_evt)      tc_flag <= 1'b1;
      else if (clr)      tc_flag <= 1'b0;

      if (coll_evt)      wcol_flag <= 1'b1;
      else if (clr)      wcol_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_cs_selgen.sv
module spi_cs_selgen #(
  parameter int NSEL = 4
) (
  input  logic            auto_en,
  input  logic            active,
  input  logic [NSEL-1:0] pattern,
  output logic [NSEL-1:0] sel_n
);
  logic force_hi;
  assign force_hi = auto_en && !active;

  for (genvar i = 0; i < NSEL; i++) begin : g_sel
    assign sel_n[i] = force_hi | pattern[i];
  end
endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl #(
  parameter int              ADDR_W    = 8,
  parameter int              REG_W     = 8,
  parameter int              NSEL      = 4,
  parameter int              HALF_DIV  = 2,
  parameter logic [ADDR_W-1:0] ADDR_STAT = 8'hED,
  parameter logic [ADDR_W-1:0] ADDR_DATA = 8'hEE,
  parameter logic [ADDR_W-1:0] ADDR_SEL  = 8'hEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NSEL-1:0]   sel_n
);
  localparam int PAD_W = REG_W - NSEL;
  localparam int GAP_W = REG_W - 3;

  logic            auto_en;
  logic [NSEL-1:0] sel_pat;
  logic            eng_busy;
  logic            eng_done;
  logic [REG_W-1:0] rx_byte;
  logic            tc_flag;
  logic            wcol_flag;

  logic hit_stat, hit_data, hit_sel;
  logic data_wr, data_acc, stat_rd, other_wr, start, collide;

  assign hit_stat = (bus_addr == ADDR_STAT);
  assign hit_data = (bus_addr == ADDR_DATA);
  assign hit_sel  = (bus_addr == ADDR_SEL);
  assign data_wr  = bus_wr && hit_data;
  assign data_acc = (bus_wr || bus_rd) && hit_data;
  assign stat_rd  = bus_rd && hit_stat;
  assign other_wr = bus_wr && !hit_data;
  assign start    = data_wr && !eng_busy;
  assign collide  = data_wr && eng_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_en <= 1'b0;
      sel_pat <= '1;
    end else begin
      if (bus_wr && hit_stat) auto_en <= bus_wdata[0];
      if (bus_wr && hit_sel)  sel_pat <= bus_wdata[NSEL-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_stat)      bus_rdata = {tc_flag, wcol_flag, {GAP_W{1'b0}}, auto_en};
      else if (hit_sel)  bus_rdata = {{PAD_W{1'b1}}, sel_pat};
      else if (hit_data) bus_rdata = rx_byte;
    end
  end

  spi_cs_shift #(.DATA_W(REG_W), .HALF_DIV(HALF_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tx_byte (bus_wdata),
    .miso    (miso),
    .busy    (eng_busy),
    .done    (eng_done),
    .sclk    (sclk),
    .mosi    (mosi),
    .rx_byte (rx_byte)
  );

  spi_cs_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_evt  (eng_done),
    .coll_evt  (collide),
    .stat_rd   (stat_rd),
    .data_acc  (data_acc),
    .other_wr  (other_wr),
    .tc_flag   (tc_flag),
    .wcol_flag (wcol_flag)
  );

  spi_cs_selgen #(.NSEL(NSEL)) u_selgen (
    .auto_en (auto_en),
    .active  (eng_busy),
    .pattern (sel_pat),
    .sel_n   (sel_n)
  );
endmodule

// File: rtl/spi_cs_chk.sv
module spi_cs_chk #(
  parameter int              ADDR_W    = 8,
  parameter int              NSEL      = 4,
  parameter logic [ADDR_W-1:0] ADDR_DATA = 8'hEE
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              sclk,
  input logic [NSEL-1:0]   sel_n,
  input logic              busy,
  input logic              auto_en,
  input logic              tc_flag,
  input logic              wcol_flag
);
  // R3
  idle_sel_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !busy) |-> (sel_n == '1));

  // R5
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  // R5
  lead_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !sclk);

  // R7
  tc_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_flag) |-> $past(busy));

  // R8
  wcol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wcol_flag) |-> $past(busy && bus_wr && bus_addr == ADDR_DATA));

  // R9
  tc_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tc_flag) |-> $past((bus_rd || bus_wr) && bus_addr == ADDR_DATA));
endmodule

bind spi_cs_ctrl spi_cs_chk #(.ADDR_W(ADDR_W), .NSEL(NSEL), .ADDR_DATA(ADDR_DATA)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .sclk      (sclk),
  .sel_n     (sel_n),
  .busy      (eng_busy),
  .auto_en   (auto_en),
  .tc_flag   (tc_flag),
  .wcol_flag (wcol_flag)
);

// File: tb/spi_cs_ctrl_bench.sv
module spi_cs_ctrl_bench;
  localparam int H    = 2;
  localparam int LAST = 2 + 15 * H;
  localparam logic [7:0] A_STAT = 8'hED;
  localparam logic [7:0] A_DATA = 8'hEE;
  localparam logic [7:0] A_SEL  = 8'hEF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sclk, mosi, miso;
  logic [3:0] sel_n;

  int checks = 0;
  int errors = 0;
  logic       cur_auto = 1'b0;
  logic [3:0] cur_pat = 4'hF;

  logic       s_clr = 1'b0;
  int         s_cnt = 0;
  logic [7:0] s_byte = '0;
  logic [7:0] m_cap = '0;

  always #5 clk = ~clk;

  spi_cs_ctrl #(.HALF_DIV(H)) u_spi_cs_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .sel_n(sel_n)
  );

  // slave model: next bit presented after each falling edge
  always @(negedge sclk or posedge s_clr) begin
    if (s_clr) s_cnt <= 0;
    else       s_cnt <= s_cnt + 1;
  end
  assign miso = (s_cnt < 8) ? s_byte[7 - s_cnt] : 1'b0;
  always @(posedge sclk) m_cap <= {m_cap[6:0], mosi};

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic exp_sclk(int k);
    return (k >= 2) && (k <= 1 + 15 * H) && (((k - 2) % (2 * H)) < H);
  endfunction

  function automatic logic [3:0] exp_sel(int k);
    if (!cur_auto) return cur_pat;
    return (k >= 1 && k <= LAST) ? cur_pat : 4'hF;
  endfunction

  // run one transfer; optional collision write, arming status read, data read at given cycles
  task automatic xfer(input logic [7:0] txb, input logic [7:0] sb,
                      input int coll_k, input int arm_k, input int dacc_k);
    @(negedge clk);
    s_byte = sb; s_clr = 1'b1;
    #1 s_clr = 1'b0;
    bus_addr = A_DATA; bus_wdata = txb; bus_wr = 1'b1;
    for (int k = 1; k <= LAST + 3; k++) begin
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      // R5 serial clock schedule
      chk($sformatf("R5 sclk k=%0d", k), {7'd0, sclk}, {7'd0, exp_sclk(k)});
      // R3 / R4 select window
      chk($sformatf("R3_R4 sel k=%0d", k), {4'd0, sel_n}, {4'd0, exp_sel(k)});
      if (k == coll_k) begin bus_addr = A_DATA; bus_wdata = ~txb; bus_wr = 1'b1; end
      if (k == arm_k)  begin bus_addr = A_STAT; bus_rd = 1'b1; end
      if (k == dacc_k) begin bus_addr = A_DATA; bus_rd = 1'b1; end
    end
    // R5 MSB first, R8 byte undisturbed by a collision
    chk("R5_R8 mosi byte", m_cap, txb);
  endtask

  initial begin
    logic [7:0] d;
    logic [7:0] txs [5] = '{8'hA5, 8'h00, 8'hFF, 8'h81, 8'h5A};
    logic [7:0] rxs [5] = '{8'h3C, 8'hFF, 8'h00, 8'h7E, 8'hC3};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sel_n", {4'd0, sel_n}, 8'h0F);
    chk("R1 sclk", {7'd0, sclk}, 8'h00);
    rd(A_STAT, d); chk("R1 status", d, 8'h00);
    rd(A_SEL, d);  chk("R1 select", d, 8'hFF);

    // R2 / R4 sweep all patterns in static mode
    for (int p = 0; p < 16; p++) begin
      wr(A_SEL, 8'(p) | 8'hA0);
      cur_pat = 4'(p);
      rd(A_SEL, d);
      chk("R2 select readback", d, 8'hF0 | 8'(p));
      chk("R4 static idle sel", {4'd0, sel_n}, {4'd0, 4'(p)});
    end

    // R12 status write behaviour
    wr(A_STAT, 8'hFF); rd(A_STAT, d); chk("R12 status ff", d, 8'h01);
    wr(A_STAT, 8'h00); rd(A_STAT, d); chk("R12 status 00", d, 8'h00);
    wr(A_STAT, 8'h01); cur_auto = 1'b1;
    wr(A_SEL, 8'h05);  cur_pat = 4'h5;
    @(negedge clk);
    chk("R3 auto idle high", {4'd0, sel_n}, 8'h0F);

    // R5 R6 R7 R9 transfers in auto mode
    for (int i = 0; i < 5; i++) begin
      xfer(txs[i], rxs[i], 0, 0, 0);
      rd(A_STAT, d); chk("R7 complete flag", d, 8'h81);
      rd(A_DATA, d); chk("R6 received byte", d, rxs[i]);
      rd(A_STAT, d); chk("R9 cleared", d, 8'h01);
    end

    // R4 static mode during a transfer
    wr(A_STAT, 8'h00); cur_auto = 1'b0;
    wr(A_SEL, 8'h09);  cur_pat = 4'h9;
    xfer(8'h69, 8'h96, 0, 0, 0);
    rd(A_STAT, d); chk("R4 R7 static status", d, 8'h80);
    rd(A_DATA, d); chk("R6 static rx", d, 8'h96);
    rd(A_STAT, d); chk("R9 static cleared", d, 8'h00);

    // R8 collision
    wr(A_STAT, 8'h01); cur_auto = 1'b1;
    wr(A_SEL, 8'h0E);  cur_pat = 4'hE;
    xfer(8'h96, 8'h55, 10, 0, 0);
    rd(A_STAT, d); chk("R8 collision flag", d, 8'hC1);
    rd(A_DATA, d); chk("R8 rx intact", d, 8'h55);
    rd(A_STAT, d); chk("R9 both cleared", d, 8'h01);

    // R10 unarmed access and cancelled sequence
    xfer(8'h3C, 8'hA5, 0, 0, 0);
    rd(A_DATA, d); chk("R6 rx before arm", d, 8'hA5);
    rd(A_STAT, d); chk("R10 unarmed data access", d, 8'h81);
    wr(A_SEL, 8'h0E);
    rd(A_DATA, d);
    rd(A_STAT, d); chk("R10 cancelled by write", d, 8'h81);
    rd(A_DATA, d);
    rd(A_STAT, d); chk("R9 cleared after rearm", d, 8'h01);

    // R11 completion in the same cycle as the clearing data read
    xfer(8'hC3, 8'h18, 5, 20, LAST);
    rd(A_STAT, d); chk("R11 complete wins, collision cleared", d, 8'h81);
    rd(A_DATA, d); chk("R11 rx", d, 8'h18);
    rd(A_STAT, d); chk("R9 final clear", d, 8'h01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule